// File: doc/BRIEF.md
# Pattern-Based SDRAM Command Sequencer

This block drives the command pins of an SDRAM device by replaying short, precomputed command programs instead of deciding the timing of each command at run time. All timing margins (activate-to-read, read-to-precharge and the rest) are worked out offline and written into a small command memory as a sequence of words, with idle gaps compressed into one word plus a repeat count. A request carries a direction (read or write) and a logical address. The direction picks one of three program slots: read, write or refresh. A slot table gives the first word and the word count of that program.

While a program plays, the block emits one command per cycle on the active-low row strobe, column strobe and write enable pins. It also drives a bank and an address bus. Bank, row and column come from the logical address through three programmable mask-and-shift stages. Each stored command carries a bank offset that is added to the mapped base bank, so one program can interleave several banks. A free-running timer marks a refresh as due. The refresh program then runs as soon as the player is idle, ahead of any waiting request.

The command memory, the slot table and the mapping registers are written through a simple write-only configuration port. That port is honoured only while nothing is playing.

Top module: `pattern_sequencer`

## Requirements
- R1: A request is taken on a clock edge where req_valid and req_ready are both high. req_write=0 plays slot 0, req_write=1 plays slot 1, and a refresh plays slot 2.
- R2: Slot i (i=0..2) is written at configuration address 64+i, with the first word in data[4:0] and the word count in data[10:5]. Playback reads that many consecutive command words, wraps from word 31 to word 0, and plays one word when the count is 0.
- R3: A command word (configuration address 0..31, data[9:0]) holds its opcode in bits [9:7]: 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, with 6 and 7 treated as idle. These drive {ras_n,cas_n,we_n} as 111, 011, 101, 100, 010 and 001.
- R4: On an idle word, bits [3:0] give a repeat count, and the idle command is held for count+1 cycles. On any other opcode those bits are ignored and the command lasts exactly one cycle.
- R5: Mapping register k at configuration address 128+k (k=0 bank, 1 row, 2 column) holds a mask in data[13:0] and a shift in data[20:16]. Each field is (logical address >> shift) AND mask, cut to the field width. addr carries the row on activate, the column on read and write, and zero on every other cycle.
- R6: On activate, read, write and precharge, bank equals the mapped base bank plus the word's bank offset in bits [6:4], modulo 8. It is zero on all other cycles.
- R7: A refresh becomes due every REF_INT clock edges, the first time on the REF_INT-th edge after reset is released. The refresh program uses base bank 0, row 0 and column 0.
- R8: A due refresh starts on the first edge at which no program is playing, ahead of any pending request. A refresh that falls due during a program waits until that program ends.
- R9: The first command of a program appears in the cycle after the start edge. busy is high in exactly the cycles that carry program commands. At least one idle cycle separates two programs. An idle player outputs 111 with bank and addr at zero.
- R10: req_ready is high only when no program is playing and no refresh is due.
- R11: A configuration write (cfg_we high at an edge) takes effect only if no program is playing at that edge. Otherwise it is dropped.
- R12: After reset, busy is 0, req_ready is 1, the pins show 111 with bank and addr at zero, and every command word, slot and mapping register is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request direction, 1 = write |
| req_addr | input | ADDR_W | Logical address of the request |
| req_ready | output | 1 | Request can be taken at the next edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration address |
| cfg_wdata | input | CFG_DW | Configuration write data |
| busy | output | 1 | A program is being played |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bank | output | BANK_W | Physical bank of the current command |
| addr | output | ROW_W | Row or column of the current command |

## Verification
The read program interleaves two banks with repeated idle gaps. The write program carries a non-zero repeat field on a write word. Together they separate correct repeat handling from repeats applied to every opcode. Single requests, back-to-back held requests, and a long stream that a refresh timer tick interrupts show whether the refresh waits for the running program and then wins over the next request. A program that wraps past the last memory word, a zero word count, and a base bank of 7 with a positive offset probe the pointer, length and bank arithmetic. A table rewrite issued while busy, followed by a replay, shows whether that write was dropped.

// File: rtl/pattern_sequencer.sv
module pattern_sequencer #(
  parameter int ADDR_W  = 32,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int PM_AW   = 5,
  parameter int REP_W   = 4,
  parameter int REF_INT = 200,
  parameter int CFG_AW  = 8,
  parameter int CFG_DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              busy,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  addr
);
  localparam int PM_DEPTH = 1 << PM_AW;
  localparam int LEN_W    = PM_AW + 1;
  localparam int OP_W     = 3;
  localparam int WORD_W   = OP_W + BANK_W + REP_W;
  localparam int SH_W     = $clog2(ADDR_W);
  localparam int SH_LSB   = 16;
  localparam int REF_W    = $clog2(REF_INT);
  localparam int NSLOT    = 3;

  localparam logic [OP_W-1:0] OP_NOP = 3'd0;
  localparam logic [OP_W-1:0] OP_ACT = 3'd1;
  localparam logic [OP_W-1:0] OP_RD  = 3'd2;
  localparam logic [OP_W-1:0] OP_WR  = 3'd3;
  localparam logic [OP_W-1:0] OP_PRE = 3'd4;
  localparam logic [OP_W-1:0] OP_REF = 3'd5;

  logic [WORD_W-1:0] pmem     [PM_DEPTH];
  logic [PM_AW-1:0]  slot_org [NSLOT];
  logic [LEN_W-1:0]  slot_len [NSLOT];
  logic [ROW_W-1:0]  map_mask [NSLOT];
  logic [SH_W-1:0]   map_sh   [NSLOT];

  logic              playing, ref_pend;
  logic [PM_AW-1:0]  ptr;
  logic [LEN_W-1:0]  left;
  logic [REP_W-1:0]  rep_cnt;
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic [REF_W-1:0]  ref_cnt;

  wire [WORD_W-1:0] word  = pmem[ptr];
  wire [OP_W-1:0]   w_op  = word[WORD_W-1 -: OP_W];
  wire [BANK_W-1:0] w_off = word[REP_W +: BANK_W];
  wire [REP_W-1:0]  w_rep = word[REP_W-1:0];
  wire              w_idle  = (w_op == OP_NOP) || (w_op > OP_REF);
  wire              advance = !w_idle || (rep_cnt == w_rep);

  wire       start_ref = !playing && ref_pend;
  wire       start_req = !playing && !ref_pend && req_valid;
  wire [1:0] sel       = start_ref ? 2'd2 : {1'b0, req_write};

  wire [ADDR_W-1:0] sh_bank = req_addr >> map_sh[0];
  wire [ADDR_W-1:0] sh_row  = req_addr >> map_sh[1];
  wire [ADDR_W-1:0] sh_col  = req_addr >> map_sh[2];
  wire [BANK_W-1:0] f_bank  = sh_bank[BANK_W-1:0] & map_mask[0][BANK_W-1:0];
  wire [ROW_W-1:0]  f_row   = sh_row[ROW_W-1:0] & map_mask[1];
  wire [COL_W-1:0]  f_col   = sh_col[COL_W-1:0] & map_mask[2][COL_W-1:0];

  wire [1:0] cfg_region = cfg_addr[CFG_AW-1 -: 2];
  wire [1:0] cfg_idx    = cfg_addr[1:0];

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata, cfg_addr, sh_bank, sh_row, sh_col,
                         map_mask[0], map_mask[2]};

  assign busy      = playing;
  assign req_ready = !playing && !ref_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      playing  <= 1'b0;
      ptr      <= '0;
      left     <= '0;
      rep_cnt  <= '0;
      cur_bank <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
    end else if (playing) begin
      if (advance) begin
        rep_cnt <= '0;
        ptr     <= ptr + PM_AW'(1);
        left    <= left - LEN_W'(1);
        if (left <= LEN_W'(1)) playing <= 1'b0;
      end else begin
        rep_cnt <= rep_cnt + REP_W'(1);
      end
    end else if (start_ref || start_req) begin
      playing  <= 1'b1;
      ptr      <= slot_org[sel];
      left     <= slot_len[sel];
      rep_cnt  <= '0;
      cur_bank <= start_ref ? '0 : f_bank;
      cur_row  <= start_ref ? '0 : f_row;
      cur_col  <= start_ref ? '0 : f_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (start_ref) ref_pend <= 1'b0;
      if (ref_cnt == REF_W'(REF_INT - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + REF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PM_DEPTH; i++) pmem[i] <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        slot_org[i] <= '0;
        slot_len[i] <= '0;
        map_mask[i] <= '0;
        map_sh[i]   <= '0;
      end
    end else if (cfg_we && !playing) begin
      case (cfg_region)
        2'd0: pmem[cfg_addr[PM_AW-1:0]] <= cfg_wdata[WORD_W-1:0];
        2'd1: if (cfg_idx != 2'd3) begin
          slot_org[cfg_idx] <= cfg_wdata[PM_AW-1:0];
          slot_len[cfg_idx] <= cfg_wdata[PM_AW +: LEN_W];
        end
        2'd2: if (cfg_idx != 2'd3) begin
          map_mask[cfg_idx] <= cfg_wdata[ROW_W-1:0];
          map_sh[cfg_idx]   <= cfg_wdata[SH_LSB +: SH_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    {ras_n, cas_n, we_n} = 3'b111;
    bank = '0;
    addr = '0;
    if (playing) begin
      case (w_op)
        OP_ACT: begin
          {ras_n, cas_n, we_n} = 3'b011;
          bank = cur_bank + w_off;
          addr = cur_row;
        end
        OP_RD: begin
          {ras_n, cas_n, we_n} = 3'b101;
          bank = cur_bank + w_off;
          addr = ROW_W'(cur_col);
        end
        OP_WR: begin
          {ras_n, cas_n, we_n} = 3'b100;
          bank = cur_bank + w_off;
          addr = ROW_W'(cur_col);
        end
        OP_PRE: begin
          {ras_n, cas_n, we_n} = 3'b010;
          bank = cur_bank + w_off;
        end
        OP_REF: {ras_n, cas_n, we_n} = 3'b001;
        default: ;
      endcase
    end
  end
endmodule

module pattern_sequencer_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] bank,
  input logic [ROW_W-1:0]  addr,
  input logic              ref_pend
);
  // R10
  ready_vs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R9
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n && we_n && bank == '0 && addr == '0));

  // R8
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ref_pend) |=> busy);

  // R3
  pin_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !({ras_n, cas_n, we_n} == 3'b110 || {ras_n, cas_n, we_n} == 3'b000));
endmodule

bind pattern_sequencer pattern_sequencer_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .bank(bank), .addr(addr), .ref_pend(ref_pend)
);

// File: tb/tb_pattern_sequencer.sv
module tb_pattern_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int REF_INT    = 200;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic        req_ready;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        busy, ras_n, cas_n, we_n;
  logic [2:0]  bank;
  logic [13:0] addr;

  pattern_sequencer #(.REF_INT(REF_INT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .busy(busy),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .bank(bank), .addr(addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  bit    chk_en = 1'b0;
  string phase = "R12 reset";

  logic [19:0] q[$];
  int m_pm [32];
  int m_org[3];
  int m_len[3];
  int m_msk[3];
  int m_sh [3];
  int m_cnt;
  bit m_pend;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] act=%0h exp=%0h", tag, phase, act, exp);
    end
  endtask

  function automatic logic [19:0] entry(int op, int b, int row, int col);
    case (op)
      1: return {3'b011, 3'(b), 14'(row)};
      2: return {3'b101, 3'(b), 14'(col)};
      3: return {3'b100, 3'(b), 14'(col)};
      4: return {3'b010, 3'(b), 14'd0};
      5: return {3'b001, 3'd0, 14'd0};
      default: return {3'b111, 3'd0, 14'd0};
    endcase
  endfunction

  function automatic void push_prog(int s, int bb, int row, int col);
    int p = m_org[s];
    int n = (m_len[s] == 0) ? 1 : m_len[s];
    for (int k = 0; k < n; k++) begin
      int w   = m_pm[p];
      int op  = (w >> 7) & 7;
      int off = (w >> 4) & 7;
      int rep = w & 15;
      int times = (op == 0 || op > 5) ? rep + 1 : 1;
      for (int t = 0; t < times; t++) q.push_back(entry(op, (bb + off) % 8, row, col));
      p = (p + 1) % 32;
    end
  endfunction

  function automatic void apply_cfg(int a, int d);
    int reg_sel = (a >> 6) & 3;
    int idx = a & 3;
    if (reg_sel == 0) m_pm[a & 31] = d & 'h3FF;
    else if (reg_sel == 1 && idx != 3) begin
      m_org[idx] = d & 31;
      m_len[idx] = (d >> 5) & 63;
    end else if (reg_sel == 2 && idx != 3) begin
      m_msk[idx] = d & 'h3FFF;
      m_sh[idx]  = (d >> 16) & 31;
    end
  endfunction

  always @(posedge clk) begin
    bit idle;
    int fb, fr, fc;
    if (!rst_n) begin
      q.delete();
      m_cnt  = 0;
      m_pend = 1'b0;
      foreach (m_pm[i]) m_pm[i] = 0;
      for (int i = 0; i < 3; i++) begin
        m_org[i] = 0; m_len[i] = 0; m_msk[i] = 0; m_sh[i] = 0;
      end
    end else begin
      idle = (q.size() == 0);
      if (!idle) void'(q.pop_front());
      if (idle) begin
        if (m_pend) begin
          push_prog(2, 0, 0, 0);
          m_pend = 1'b0;
        end else if (req_valid) begin
          fb = int'((req_addr >> m_sh[0]) & 32'(m_msk[0])) & 7;
          fr = int'((req_addr >> m_sh[1]) & 32'(m_msk[1])) & 'h3FFF;
          fc = int'((req_addr >> m_sh[2]) & 32'(m_msk[2])) & 'h3FF;
          push_prog(req_write ? 1 : 0, fb, fr, fc);
        end
        if (cfg_we) apply_cfg(int'(cfg_addr), int'(cfg_wdata));
      end
      if (m_cnt == REF_INT - 1) begin
        m_cnt  = 0;
        m_pend = 1'b1;
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    logic [19:0] e;
    bit eb;
    if (chk_en) begin
      e  = (q.size() != 0) ? q[0] : {3'b111, 17'd0};
      eb = (q.size() != 0);
      check("R3 pins", int'({ras_n, cas_n, we_n}), int'(e[19:17]));
      check("R6 bank", int'(bank), int'(e[16:14]));
      check("R5 addr", int'(addr), int'(e[13:0]));
      check("R9 busy", int'(busy), int'(eb));
      check("R10 ready", int'(req_ready), int'(!eb && !m_pend));
    end
  end

  function automatic int cw(int op, int off, int rep);
    return (op << 7) | (off << 4) | rep;
  endfunction

  task automatic cfg(int a, int d);
    while (busy || !req_ready) @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(bit wr, logic [31:0] a);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(int row, int b, int col);
    return 32'((row << 16) | (b << 13) | (col << 3) | 5);
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R12 busy", int'(busy), 0);
    check("R12 pins", int'({ras_n, cas_n, we_n}), 7);
    check("R12 bank", int'(bank), 0);
    check("R12 addr", int'(addr), 0);
    check("R12 ready", int'(req_ready), 1);
    chk_en = 1'b1;

    phase = "R2 program";
    cfg(0, cw(1,0,0)); cfg(1, cw(0,0,2)); cfg(2, cw(1,1,0)); cfg(3, cw(2,0,0));
    cfg(4, cw(0,0,1)); cfg(5, cw(2,0,0)); cfg(6, cw(2,1,0)); cfg(7, cw(0,0,0));
    cfg(8, cw(2,1,0)); cfg(9, cw(4,0,0)); cfg(10, cw(4,1,0));
    cfg(12, cw(1,0,0)); cfg(13, cw(0,0,3)); cfg(14, cw(3,0,0)); cfg(15, cw(3,0,5));
    cfg(16, cw(0,0,2)); cfg(17, cw(4,0,0));
    cfg(20, cw(4,0,0)); cfg(21, cw(0,0,1)); cfg(22, cw(5,0,0)); cfg(23, cw(0,0,4));
    cfg(64, (11 << 5) | 0); cfg(65, (6 << 5) | 12); cfg(66, (4 << 5) | 20);
    cfg(128, (13 << 16) | 7); cfg(129, (16 << 16) | 'h3FFF); cfg(130, (3 << 16) | 'h3FF);

    phase = "R1 read";   send(1'b0, mk('h123, 5, 'h2A)); wait_idle();
    phase = "R1 write";  send(1'b1, mk('h3F0, 2, 'h155)); wait_idle();
    phase = "R4 repeat"; send(1'b1, mk('h001, 0, 'h3FF)); wait_idle();

    phase = "R11 busy cfg";
    send(1'b0, mk('h0AA, 3, 'h011));
    cfg_we = 1'b1; cfg_addr = 8'd0; cfg_wdata = 32'(cw(5,0,0));
    @(negedge clk);
    cfg_addr = 8'd64; cfg_wdata = 32'((1 << 5) | 22);
    @(negedge clk);
    cfg_we = 1'b0;
    wait_idle();
    phase = "R11 replay"; send(1'b0, mk('h0AB, 3, 'h012)); wait_idle();

    phase = "R6 wrap";   send(1'b0, mk('h200, 7, 'h080)); wait_idle();

    phase = "R5 remap";
    cfg(129, (20 << 16) | 'hFF); cfg(130, (0 << 16) | 'h0F); cfg(128, (1 << 16) | 3);
    send(1'b0, 32'hDEAD_BEEF); wait_idle();
    send(1'b1, 32'h1234_5678); wait_idle();

    phase = "R2 wrap";
    cfg(30, cw(1,1,0)); cfg(31, cw(0,0,1)); cfg(65, (4 << 5) | 30);
    send(1'b1, 32'h0F0F_0F0F); wait_idle();
    phase = "R2 zero len";
    cfg(65, (0 << 5) | 30);
    send(1'b1, 32'h0000_00FF); wait_idle();
    cfg(65, (6 << 5) | 12);

    phase = "R7 idle refresh";
    repeat (REF_INT + 20) @(negedge clk);

    phase = "R8 stream";
    for (int i = 0; i < 50; i++) send(i[0], 32'(i * 32'h0101_2345));
    wait_idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    $display("FAIL watchdog [%s] act=hung exp=done", phase);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule